// File: doc/BRIEF.md
# Burst Duty-Cycle Power Transfer Controller

This controller gates an isolated power converter in bursts. Time is split into fixed-length periods. Each period holds fifteen equal slots, and each slot lasts `SLOT_CYC` clocks. The converter runs for an even number of leading slots, set by one of seven transfer levels: level k keeps the gate high for the first 2k slots. This gives duty cycles of 2/15 through 14/15.

The level comes from a 3-bit code delivered by a resistor-decode front end, together with an invalid flag for an open or shorted pin. The level is latched once, when the primary supply becomes good, and it holds until that supply drops and returns. Power-up runs a fixed sequence. After the supply is seen good, one capture cycle samples the code. The gate then stays high without a break for `STARTUP_CYC` clocks, and after that the periodic bursts begin. Each period is announced by a one-cycle burst-start strobe.

The control is a four-state machine:
- `ST_OFF`: supply absent.
- `ST_CAPT`: one-cycle code capture.
- `ST_START`: continuous start-up transfer.
- `ST_BURST`: periodic operation.

Its transitions are:
- OFF→CAPT when supply is good.
- CAPT→START unconditionally.
- START→BURST when the start-up count expires.
- Any state→OFF when supply is lost.

Top module: `burst_xfer_ctrl`

## Requirements
- R1: Codes 3'b001 to 3'b111 select levels 1 to 7. In `ST_BURST`, `conv_on` is high exactly while the slot index (0 to 14) is below 2×level.
- R2: The burst period is always 15×`SLOT_CYC` clocks, whatever the level. The last clock of every period has `conv_on` low for levels 1 to 7, except that level 7 leaves only slot 14 low.
- R3: The level is taken from `set_code`/`set_invalid` only in the capture cycle. Later changes have no effect on `conv_on` until the supply cycles, and the next power-up uses the new code.
- R4: Code 3'b000, or `set_invalid` high in the capture cycle, selects level 1 (2 of 15 slots on).
- R5: After the capture cycle, `conv_on` is high for exactly `STARTUP_CYC` consecutive clocks before the first period starts.
- R6: `burst_start` is high for one clock at clock 0 of slot 0 of every period. The first strobe falls on the clock right after start-up ends, and `conv_on` is high on every strobe clock.
- R7: A clock edge that sees `supply_ok` low puts the block in `ST_OFF`, with `conv_on` and `burst_start` low from that edge on and all counters cleared. A later power-up restarts from capture.
- R8: While `rst_n` is low, both outputs are low, regardless of `supply_ok`.
- R9: From `ST_OFF`, the first edge with `supply_ok` high enters `ST_CAPT`. Both outputs stay low in the `ST_OFF` and `ST_CAPT` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Primary supply good |
| set_code | input | 3 | Raw transfer-level code from the decode front end |
| set_invalid | input | 1 | Decode flagged the pin as open or shorted |
| conv_on | output | 1 | Converter run gate |
| burst_start | output | 1 | One-cycle strobe at the start of every period |
| | | | |

## Verification
Supply loss and the burst-start strobe can fall on the same clock. The bench provokes this by dropping `supply_ok` at the edge where a period begins: a run is timed so that its final sample index lands on clock 0 of the third period. The scoreboard expects the strobe and the high gate to appear on that one clock, followed by an all-low `ST_OFF` sample on the next clock with no second strobe. It also ends a run inside start-up, which checks that the start-up count is cleared and the next power-up again shows a full `STARTUP_CYC` high stretch.

// File: rtl/bxc_pkg.sv
package bxc_pkg;

    localparam int NUM_SLOTS = 15;
    localparam int SLOT_W    = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CAPT,
        ST_START,
        ST_BURST
    } bxc_state_t;

    // Map the raw code to a level 1..7; zero or a flagged decode gives 1.
    function automatic logic [2:0] bxc_decode_level(input logic [2:0] code,
                                                    input logic       invalid);
        logic [2:0] lvl;
        if (invalid || (code == 3'd0)) begin
            lvl = 3'd1;
        end else begin
            lvl = code;
        end
        return lvl;
    endfunction

endpackage

// File: rtl/bxc_code_latch.sv
module bxc_code_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_en,
    input  logic [2:0] set_code,
    input  logic       set_invalid,
    output logic [2:0] level_q
);
    import bxc_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 3'd1;
        end else if (cap_en) begin
            level_q <= bxc_decode_level(set_code, set_invalid);
        end
    end

    // R3: the held level only moves in the capture cycle
    p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(level_q));

    // R4: the held level is always one of the seven levels
    p_level_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q >= 3'd1) && (level_q <= 3'd7));

endmodule

// File: rtl/bxc_startup_timer.sv
module bxc_startup_timer #(
    parameter int STARTUP_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(STARTUP_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && (cnt_q == CW'(STARTUP_CYC - 1));

    // R5: the start-up count never runs past its last cycle
    p_start_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(STARTUP_CYC - 1));

endmodule

// File: rtl/bxc_slot_timer.sv
module bxc_slot_timer #(
    parameter int SLOT_CYC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    output logic [bxc_pkg::SLOT_W-1:0] slot_idx,
    output logic                      period_first
);
    import bxc_pkg::*;

    localparam int CW = $clog2(SLOT_CYC + 1);

    logic [CW-1:0]     cyc_q;
    logic [SLOT_W-1:0] slot_q;
    logic              slot_end;
    logic              period_end;

    assign slot_end   = (cyc_q == CW'(SLOT_CYC - 1));
    assign period_end = slot_end && (slot_q == SLOT_W'(NUM_SLOTS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (!run) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (period_end) begin
            cyc_q  <= '0;
            slot_q <= '0;
        end else if (slot_end) begin
            cyc_q  <= '0;
            slot_q <= slot_q + 1'b1;
        end else begin
            cyc_q  <= cyc_q + 1'b1;
        end
    end

    assign slot_idx     = slot_q;
    assign period_first = run && (cyc_q == '0) && (slot_q == '0);

    // R2: the slot index stays inside the fifteen-slot period
    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q < SLOT_W'(NUM_SLOTS));

endmodule

// File: rtl/burst_xfer_ctrl.sv
module burst_xfer_ctrl #(
    parameter int SLOT_CYC    = 4,
    parameter int STARTUP_CYC = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic [2:0] set_code,
    input  logic       set_invalid,
    output logic       conv_on,
    output logic       burst_start
);
    import bxc_pkg::*;

    bxc_state_t        state_q;
    bxc_state_t        state_d;
    logic [2:0]        level_q;
    logic              start_done;
    logic [SLOT_W-1:0] slot_idx;
    logic              period_first;
    logic [SLOT_W-1:0] on_slots;

    bxc_code_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (state_q == ST_CAPT),
        .set_code    (set_code),
        .set_invalid (set_invalid),
        .level_q     (level_q)
    );

    bxc_startup_timer #(.STARTUP_CYC(STARTUP_CYC)) u_start (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_START),
        .done  (start_done)
    );

    bxc_slot_timer #(.SLOT_CYC(SLOT_CYC)) u_slot (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (state_q == ST_BURST),
        .slot_idx     (slot_idx),
        .period_first (period_first)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (supply_ok) state_d = ST_CAPT;
            ST_CAPT:  state_d = ST_START;
            ST_START: if (start_done) state_d = ST_BURST;
            ST_BURST: state_d = ST_BURST;
            default:  state_d = ST_OFF;
        endcase
        if (!supply_ok) begin
            state_d = ST_OFF;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign on_slots = {level_q, 1'b0};

    // Outputs
    always_comb begin
        conv_on     = 1'b0;
        burst_start = 1'b0;
        unique case (state_q)
            ST_OFF, ST_CAPT: begin
                conv_on     = 1'b0;
                burst_start = 1'b0;
            end
            ST_START: conv_on = 1'b1;
            ST_BURST: begin
                conv_on     = (slot_idx < on_slots);
                burst_start = period_first;
            end
            default: ;
        endcase
    end

    // R7: a cycle with the supply absent is followed by silent outputs
    p_off_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!conv_on && !burst_start));

    // R6: a period strobe always falls inside the on-time
    p_strobe_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> conv_on);

    // R6: the strobe lasts one clock
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> !burst_start);

    // R9: capture lasts exactly one clock
    p_capt_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPT) |=> (state_q == ST_START || state_q == ST_OFF));

endmodule

// File: tb/sim_burst_xfer_ctrl.sv
module sim_burst_xfer_ctrl;

    localparam int CLK_PER  = 10;
    localparam int SLOT     = 4;
    localparam int STARTUP  = 20;
    localparam int PERIOD   = 15 * SLOT;

    typedef struct {
        logic  on;
        logic  strobe;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic [2:0] set_code = 3'd0;
    logic       set_invalid = 1'b0;
    logic       conv_on;
    logic       burst_start;

    int   n_chk = 0;
    int   n_fail = 0;
    exp_t q[$];

    burst_xfer_ctrl #(.SLOT_CYC(SLOT), .STARTUP_CYC(STARTUP)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .set_code    (set_code),
        .set_invalid (set_invalid),
        .conv_on     (conv_on),
        .burst_start (burst_start)
    );

    always #(CLK_PER / 2) clk = ~clk;

    // Expected outputs at sample i after the supply is raised.
    function automatic exp_t exp_at(input int i, input int lvl, input string rtag);
        exp_t e;
        int   j;
        int   p;
        if (i < 2) begin
            e.on = 1'b0; e.strobe = 1'b0; e.tag = "R9";
        end else if (i < 2 + STARTUP) begin
            e.on = 1'b1; e.strobe = 1'b0; e.tag = "R5";
        end else begin
            j = i - 2 - STARTUP;
            p = j % PERIOD;
            e.on     = ((p / SLOT) < 2 * lvl);
            e.strobe = (p == 0);
            if (p == 0) e.tag = "R6";
            else if (p == PERIOD - 1) e.tag = "R2";
            else e.tag = rtag;
        end
        return e;
    endfunction

    // Monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (conv_on !== e.on || burst_start !== e.strobe) begin
                n_fail++;
                $display("FAIL %s: actual on=%b strobe=%b expected on=%b strobe=%b at %0t",
                         e.tag, conv_on, burst_start, e.on, e.strobe, $time);
            end
        end
    end

    task automatic power_run(input logic [2:0] code, input logic inv, input int lvl,
                             input int m, input string rtag,
                             input int chg_at, input logic [2:0] chg_code);
        exp_t z;
        @(posedge clk); #1;
        set_code = code;
        set_invalid = inv;
        supply_ok = 1'b1;
        for (int i = 0; i <= m; i++) q.push_back(exp_at(i, lvl, rtag));
        z.on = 1'b0; z.strobe = 1'b0; z.tag = "R7";
        q.push_back(z);
        q.push_back(z);
        for (int c = 0; c < m; c++) begin
            @(posedge clk); #1;
            if (c == chg_at) begin
                set_code = chg_code;
                set_invalid = 1'b0;
            end
        end
        supply_ok = 1'b0;
        repeat (3) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic check_reset;
        @(negedge clk);
        n_chk++;
        if (conv_on !== 1'b0 || burst_start !== 1'b0) begin
            n_fail++;
            $display("FAIL R8: actual on=%b strobe=%b expected on=0 strobe=0",
                     conv_on, burst_start);
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL R7: watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R8: reset holds outputs low even with supply present
        supply_ok = 1'b1;
        set_code = 3'd7;
        repeat (3) check_reset();
        @(posedge clk); #1;
        supply_ok = 1'b0;
        rst_n = 1'b1;
        repeat (2) begin
            @(posedge clk); #1;
        end

        // R1: every level, two full periods, dropped on the third strobe
        for (int k = 1; k <= 7; k++) begin
            power_run(3'(k), 1'b0, k, 2 + STARTUP + 2 * PERIOD, "R1", -1, 3'd0);
        end

        // R4: zero code and a flagged decode both give level 1
        power_run(3'd0, 1'b0, 1, 2 + STARTUP + PERIOD + 7, "R4", -1, 3'd0);
        power_run(3'd7, 1'b1, 1, 2 + STARTUP + PERIOD + 7, "R4", -1, 3'd0);

        // R3: a code change after capture is ignored until the supply cycles
        power_run(3'd2, 1'b0, 2, 2 + STARTUP + 2 * PERIOD, "R3", 10, 3'd7);
        power_run(3'd7, 1'b0, 7, 2 + STARTUP + PERIOD + 3, "R3", -1, 3'd0);

        // R7: loss of supply inside start-up, then a clean restart
        power_run(3'd3, 1'b0, 3, 10, "R7", -1, 3'd0);
        power_run(3'd3, 1'b0, 3, 2 + STARTUP + PERIOD + 1, "R7", -1, 3'd0);

        repeat (2) begin
            @(posedge clk); #1;
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule